// File: doc/BRIEF.md
# Misaligned Access Bus Cycle Splitter

This block sits between a load/store unit and a 64-bit external data bus. The bus carries a line address (the byte address with its three lowest bits removed) and eight active-low byte enables, one per 8-bit lane. The block takes one access at a time: a byte address, an operand size of 1, 2, 4 or 8 bytes, a read/write flag and right-justified write data. It decides whether the access fits in one bus cycle or needs two. For each cycle it drives the line address, the byte-enable mask and the write data steered onto the correct lanes. For reads it collects the returned lanes from both cycles and presents the operand right-justified.

The split rule is not only an 8-byte line-crossing test. A two-byte operand also splits when it straddles the 4-byte boundary inside a line. A four-byte operand goes in one cycle only when it is 4-byte aligned. An eight-byte operand goes in one cycle only when it is 8-byte aligned. In a split access the higher-addressed part of the operand is moved first and the lower-addressed part second. The split point is the next 4-byte boundary above the start address for 2- and 4-byte operands, and the next 8-byte boundary for 8-byte operands.

The controller has four states. ST_IDLE waits for a request and goes to ST_LEAD when one is accepted. ST_LEAD drives the first bus cycle. When the bus acknowledges it, the controller goes to ST_TRAIL if the access is split and to ST_FINISH if it is not. ST_TRAIL drives the second cycle and goes to ST_FINISH on acknowledge. ST_FINISH raises the done pulse for one cycle and returns to ST_IDLE.

Top module: `bus_split_unit`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the cycle after the `done` pulse.
- R2: A 1-byte access (`req_size` = 0) always takes exactly one bus cycle, whatever the low three address bits are.
- R3: A 2-byte access (`req_size` = 1) takes two bus cycles when the low three address bits are 3 or 7, and one cycle at every other offset.
- R4: A 4-byte access (`req_size` = 2) takes one bus cycle when the low three address bits are 0 or 4, and two cycles at every other offset.
- R5: An 8-byte access (`req_size` = 3) takes one bus cycle at offset 0 and two cycles at every other offset.
- R6: In a split access, the first cycle moves the operand bytes whose addresses are at or above the split point, and the second cycle moves the rest. Together the two cycles move exactly 1 << `req_size` bytes.
- R7: `bus_line_addr` equals address bit 3 and up. In the first cycle of a split access that crosses an 8-byte line, it is one line higher (wrapping at the top of the address space). Every other cycle drives the original line.
- R8: `bus_be_n` bit k is driven low exactly when lane k (byte address mod 8 = k) takes part in the cycle. The enabled lanes form one contiguous run. All bits are high whenever `bus_req` is low.
- R9: On a write, operand byte i (bits 8i+7..8i of `req_wdata`) appears on lane (address + i) mod 8 of `bus_wdata`. Disabled lanes are zero, `bus_wdata` is all zero during reads, and `bus_write` equals the request's write flag while `bus_req` is high.
- R10: `done` is high for exactly one cycle, the cycle after the last acknowledged bus cycle. On a read, `rdata` then holds byte i of the operand, taken from lane (address + i) mod 8 of the cycle that moved it, in bits 8i+7..8i, with bytes at and above the operand size zero. After a write `rdata` is zero. Data on disabled lanes is ignored.
- R11: While `bus_req` is high and `bus_ack` is low, the line address, enables, write data and write flag hold their values. The second cycle is not driven before the first is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Right-justified write operand |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Right-justified read operand, valid with done |
| bus_req | output | 1 | A bus cycle is being driven |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_line_addr | output | ADDR_W-3 | Line address (byte address bits 3 and up) |
| bus_be_n | output | 8 | Active-low byte-lane enables |
| bus_wdata | output | 64 | Lane-steered write data |
| bus_rdata | input | 64 | Lane data returned by the bus |
| bus_ack | input | 1 | Bus has completed the current cycle |

## Verification
The bound checker watches, on every cycle, that the request handshake is closed outside the idle state, that the bus outputs hold while a cycle waits for its acknowledge, and that every driven enable mask is one non-empty contiguous run. It also checks that written lanes stay inside that mask, and that each completed access used the expected number of cycles for its size and offset and moved exactly its operand's byte count. The exact lane positions, the order of the high and low parts, the line increment on a crossing (including wrap at the top of the address space) and the reassembled read value can only be seen in the bench's sweep. That sweep covers every size and offset at three line addresses, in both directions, with varying acknowledge delays.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int BUS_W  = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int CNT_W  = OFF_W + 1;
    localparam int RUN_W  = 2 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_FINISH
    } split_state_e;

    typedef struct packed {
        logic             split;
        logic             line_inc;
        logic [LANES-1:0] lead_mask;
        logic [LANES-1:0] trail_mask;
    } cycle_plan_t;

    // contiguous run of n lanes starting at lane 'start'
    function automatic logic [LANES-1:0] lane_run(input logic [OFF_W-1:0] start,
                                                  input logic [CNT_W-1:0] n);
        logic [RUN_W-1:0] w;
        w = (RUN_W'(1) << n) - RUN_W'(1);
        w = w << start;
        return w[LANES-1:0];
    endfunction

    function automatic logic [BUS_W-1:0] lane_expand(input logic [LANES-1:0] m);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        end
        return r;
    endfunction
endpackage

// File: rtl/bsu_split_plan.sv
module bsu_split_plan
    import bsu_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  op_size_e         size,
    output cycle_plan_t      plan
);
    logic [CNT_W-1:0] nbytes;
    logic [CNT_W-1:0] boundary;
    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;

    always_comb begin
        nbytes = CNT_W'(1) << size;
        // split point: next line for 8-byte operands, next half-line otherwise
        if (size == SZ_DWORD) begin
            boundary = CNT_W'(LANES);
        end else if (offset[OFF_W-1]) begin
            boundary = CNT_W'(LANES);
        end else begin
            boundary = CNT_W'(LANES / 2);
        end
        lo_cnt = boundary - CNT_W'(offset);
        hi_cnt = nbytes - lo_cnt;

        plan.split    = (nbytes > lo_cnt);
        plan.line_inc = plan.split && boundary[OFF_W];
        if (plan.split) begin
            plan.lead_mask  = lane_run(boundary[OFF_W-1:0], hi_cnt);
            plan.trail_mask = lane_run(offset, lo_cnt);
        end else begin
            plan.lead_mask  = lane_run(offset, nbytes);
            plan.trail_mask = '0;
        end
    end
endmodule

// File: rtl/bsu_lane_rotate.sv
module bsu_lane_rotate #(
    parameter int LANES       = 8,
    parameter int LANE_W      = 8,
    parameter bit TOWARD_HIGH = 1'b1
) (
    input  logic [LANES*LANE_W-1:0]  din,
    input  logic [$clog2(LANES)-1:0] amount,
    output logic [LANES*LANE_W-1:0]  dout
);
    localparam int SH_W = $clog2(LANES);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [SH_W-1:0] src;
        if (TOWARD_HIGH) begin : g_up
            assign src = SH_W'(j) - amount;
        end else begin : g_down
            assign src = SH_W'(j) + amount;
        end
        assign dout[j*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
    import bsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic [BUS_W-1:0]        req_wdata,
    output logic                    done,
    output logic [BUS_W-1:0]        rdata,
    output logic                    bus_req,
    output logic                    bus_write,
    output logic [ADDR_W-OFF_W-1:0] bus_line_addr,
    output logic [LANES-1:0]        bus_be_n,
    output logic [BUS_W-1:0]        bus_wdata,
    input  logic [BUS_W-1:0]        bus_rdata,
    input  logic                    bus_ack
);
    localparam int LINE_W = ADDR_W - OFF_W;

    split_state_e     state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    op_size_e          size_q;
    logic              wr_q;
    logic [BUS_W-1:0]  wrot_q;
    logic [BUS_W-1:0]  acc_q;

    logic [OFF_W-1:0]  offset_q;
    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  nbytes_q;
    logic [LANES-1:0]  cur_mask;
    logic [BUS_W-1:0]  wrot_d;
    logic [BUS_W-1:0]  rd_rot;
    cycle_plan_t       plan;
    logic              accept;

    assign offset_q = addr_q[OFF_W-1:0];
    assign line_q   = addr_q[ADDR_W-1:OFF_W];
    assign nbytes_q = CNT_W'(1) << size_q;
    assign accept   = req_valid && (state_q == ST_IDLE);

    bsu_split_plan u_plan (
        .offset (offset_q),
        .size   (size_q),
        .plan   (plan)
    );

    bsu_lane_rotate #(.LANES(LANES), .LANE_W(LANE_W), .TOWARD_HIGH(1'b1)) u_wr_steer (
        .din    (req_wdata),
        .amount (req_addr[OFF_W-1:0]),
        .dout   (wrot_d)
    );

    bsu_lane_rotate #(.LANES(LANES), .LANE_W(LANE_W), .TOWARD_HIGH(1'b0)) u_rd_align (
        .din    (acc_q),
        .amount (offset_q),
        .dout   (rd_rot)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LEAD;
            ST_LEAD:   if (bus_ack) state_d = plan.split ? ST_TRAIL : ST_FINISH;
            ST_TRAIL:  if (bus_ack) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request and read accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= SZ_BYTE;
            wr_q   <= 1'b0;
            wrot_q <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            size_q <= op_size_e'(req_size);
            wr_q   <= req_write;
            wrot_q <= wrot_d;
            acc_q  <= '0;
        end else if (bus_req && bus_ack && !wr_q) begin
            acc_q <= acc_q | (bus_rdata & lane_expand(cur_mask));
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        bus_req       = 1'b0;
        bus_write     = 1'b0;
        bus_line_addr = line_q;
        bus_be_n      = '1;
        bus_wdata     = '0;
        done          = 1'b0;
        rdata         = '0;
        cur_mask      = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LEAD: begin
                bus_req       = 1'b1;
                cur_mask      = plan.lead_mask;
                bus_line_addr = line_q + LINE_W'(plan.line_inc);
            end
            ST_TRAIL: begin
                bus_req  = 1'b1;
                cur_mask = plan.trail_mask;
            end
            ST_FINISH: begin
                done  = 1'b1;
                rdata = rd_rot & lane_expand(lane_run('0, nbytes_q));
            end
            default: ;
        endcase
        if (bus_req) begin
            bus_be_n  = ~cur_mask;
            bus_write = wr_q;
            bus_wdata = wr_q ? (wrot_q & lane_expand(cur_mask)) : '0;
        end
    end
endmodule

// File: rtl/bsu_split_checker.sv
module bsu_split_checker
    import bsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [OFF_W-1:0]        req_off,
    input logic [1:0]              req_size,
    input logic                    req_write,
    input logic                    done,
    input logic [BUS_W-1:0]        rdata,
    input logic                    bus_req,
    input logic                    bus_write,
    input logic [ADDR_W-OFF_W-1:0] bus_line_addr,
    input logic [LANES-1:0]        bus_be_n,
    input logic [BUS_W-1:0]        bus_wdata,
    input logic                    bus_ack
);
    logic [OFF_W-1:0] off_c;
    logic [1:0]       size_c;
    logic             wr_c;
    logic [1:0]       ack_cnt;
    logic [CNT_W-1:0] lane_cnt;
    logic [LANES-1:0] en;

    assign en = ~bus_be_n;

    function automatic logic [1:0] exp_cycles(input logic [1:0] sz, input logic [OFF_W-1:0] off);
        case (sz)
            2'd0:    return 2'd1;
            2'd1:    return (off == 3'd3 || off == 3'd7) ? 2'd2 : 2'd1;
            2'd2:    return (off == 3'd0 || off == 3'd4) ? 2'd1 : 2'd2;
            default: return (off == 3'd0) ? 2'd1 : 2'd2;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_c    <= '0;
            size_c   <= '0;
            wr_c     <= 1'b0;
            ack_cnt  <= '0;
            lane_cnt <= '0;
        end else if (req_valid && req_ready) begin
            off_c    <= req_off;
            size_c   <= req_size;
            wr_c     <= req_write;
            ack_cnt  <= '0;
            lane_cnt <= '0;
        end else if (bus_req && bus_ack) begin
            ack_cnt  <= ack_cnt + 2'd1;
            lane_cnt <= lane_cnt + CNT_W'($countones(en));
        end
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !done));

    p_busy_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);

    // R2, R4 and R5 are covered by the same count check
    p_cycle_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ack_cnt == exp_cycles(size_c, off_c)));

    p_byte_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lane_cnt == (CNT_W'(1) << size_c)));

    p_idle_lanes_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_be_n == '1));

    p_lanes_contiguous_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((en != '0) && (((en + (en & (~en + 1'b1))) & en) == '0)));

    p_wdata_in_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((bus_wdata & ~lane_expand(en)) == '0));

    p_write_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_write == wr_c));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_c) |-> (rdata == '0));

    p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_line_addr) && $stable(bus_be_n)
                                   && $stable(bus_wdata) && $stable(bus_write)));
endmodule

bind bus_split_unit bsu_split_checker #(.ADDR_W(ADDR_W)) u_split_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_addr[2:0]),
    .req_size      (req_size),
    .req_write     (req_write),
    .done          (done),
    .rdata         (rdata),
    .bus_req       (bus_req),
    .bus_write     (bus_write),
    .bus_line_addr (bus_line_addr),
    .bus_be_n      (bus_be_n),
    .bus_wdata     (bus_wdata),
    .bus_ack       (bus_ack)
);

// File: tb/tb_bus_split_unit.sv
`timescale 1ns/1ps
module tb_bus_split_unit;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        done;
    logic [63:0] rdata;
    logic        bus_req;
    logic        bus_write;
    logic [28:0] bus_line_addr;
    logic [7:0]  bus_be_n;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bus_split_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .rdata(rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_line_addr(bus_line_addr),
        .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'h1D;
        return p ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic run_op(input logic [31:0] a, input int sz, input bit wr,
                          input logic [63:0] wd, input int lag);
        int          n;
        bit          exp_split;
        logic [2:0]  off;
        logic [7:0]  m1, m2;
        logic [28:0] l1, l2;
        logic [63:0] d1, d2, exp_rd;
        int          cyc, wt;
        bit          got_done;
        string       cnt_tag;

        n   = 1 << sz;
        off = a[2:0];
        case (sz)
            0: begin exp_split = 1'b0;                          cnt_tag = "R2"; end
            1: begin exp_split = (off == 3 || off == 7);        cnt_tag = "R3"; end
            2: begin exp_split = !(off == 0 || off == 4);       cnt_tag = "R4"; end
            default: begin exp_split = (off != 0);              cnt_tag = "R5"; end
        endcase
        m1 = '0; m2 = '0; d1 = '0; d2 = '0; exp_rd = '0;
        l1 = a[31:3]; l2 = a[31:3];
        for (int i = 0; i < n; i++) begin
            logic [31:0] ba;
            bit hi, first;
            ba = a + 32'(i);
            hi = (sz == 3) ? (ba[31:3] != a[31:3]) : (ba[31:2] != a[31:2]);
            first = !exp_split || hi;
            exp_rd[i*8 +: 8] = mem_byte(ba);
            if (first) begin
                m1[ba[2:0]] = 1'b1;
                l1 = ba[31:3];
                d1[ba[2:0]*8 +: 8] = wd[i*8 +: 8];
            end else begin
                m2[ba[2:0]] = 1'b1;
                l2 = ba[31:3];
                d2[ba[2:0]*8 +: 8] = wd[i*8 +: 8];
            end
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 ready low after accept", 64'(req_ready), 64'd0);

        cyc = 0; wt = lag; got_done = 1'b0;
        for (int k = 0; k < 40 && !got_done; k++) begin
            if (k > 0) @(negedge clk);
            bus_ack = 1'b0;
            if (done) begin
                got_done = 1'b1;
                check(cyc == (exp_split ? 2 : 1), {cnt_tag, " bus cycle count"},
                      64'(cyc), exp_split ? 64'd2 : 64'd1);
                check(rdata == (wr ? 64'd0 : exp_rd), "R10 read operand", rdata,
                      wr ? 64'd0 : exp_rd);
            end else if (bus_req) begin
                check(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
                if (wt > 0) begin
                    wt--;
                    check(bus_be_n == ~((cyc == 0) ? m1 : m2), "R11 hold before ack",
                          64'(bus_be_n), 64'(~((cyc == 0) ? m1 : m2)));
                end else begin
                    cyc++;
                    if (cyc == 1) begin
                        check(bus_line_addr == l1, "R7 first line", 64'(bus_line_addr), 64'(l1));
                        check(bus_be_n == ~m1, "R6 R8 first enables", 64'(bus_be_n), 64'(~m1));
                        check(bus_wdata == (wr ? d1 : 64'd0), "R9 first data", bus_wdata,
                              wr ? d1 : 64'd0);
                    end else begin
                        check(bus_line_addr == l2, "R7 second line", 64'(bus_line_addr), 64'(l2));
                        check(bus_be_n == ~m2, "R6 R8 second enables", 64'(bus_be_n), 64'(~m2));
                        check(bus_wdata == (wr ? d2 : 64'd0), "R9 second data", bus_wdata,
                              wr ? d2 : 64'd0);
                    end
                    check(bus_write == wr, "R9 write flag", 64'(bus_write), 64'(wr));
                    for (int ln = 0; ln < 8; ln++) begin
                        bus_rdata[ln*8 +: 8] = mem_byte({bus_line_addr, 3'(ln)});
                    end
                    bus_ack = 1'b1;
                    wt = lag;
                end
            end
        end
        check(got_done, "R10 done seen", 64'(got_done), 64'd1);
        @(negedge clk);
        check(done == 1'b0, "R10 done is a pulse", 64'(done), 64'd0);
        check(req_ready == 1'b1, "R1 ready back after done", 64'(req_ready), 64'd1);
        check(bus_be_n == 8'hFF, "R8 idle enables high", 64'(bus_be_n), 64'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] bases [3];
        int idx;
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0000_1238;
        bases[2] = 32'hFFFF_FFF8;
        idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        check(bus_req == 1'b0, "R8 reset no cycle", 64'(bus_req), 64'd0);
        check(bus_be_n == 8'hFF, "R8 reset enables", 64'(bus_be_n), 64'hFF);
        check(done == 1'b0, "R10 reset done low", 64'(done), 64'd0);
        for (int b = 0; b < 3; b++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < 8; off++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        logic [63:0] wd;
                        wd = 64'h0123_4567_89AB_CDEF ^ {8{8'(idx * 37)}};
                        run_op(bases[b] + 32'(off), sz, wr[0], wd, idx % 3);
                        idx++;
                    end
                end
            end
        end
        report();
        $finish;
    end
endmodule